// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Flag Generation

This block is the purely combinational datapath of an 8-bit processor's execute stage. Each cycle it takes an operation code, the accumulator value, a second operand and the current flag byte. It returns the new result byte, the new flag byte and a write strobe for the accumulator. There is no state inside: the outputs settle from the inputs in the same cycle, and the surrounding pipeline decides when to capture them.

The operation set covers the following:
- byte addition and subtraction, each with and without carry-in;
- compare, negate and increment/decrement;
- the three bitwise logic operations, plus a test form of AND that only sets flags;
- two families of rotates and shifts, one that acts on a general byte and one that acts on the accumulator alone;
- an unsigned multiply of the two halves of a 16-bit register pair.

The multiply result goes out on its own 16-bit port, with its own write strobe for the pair. Every operation produces a complete flag byte. The rules for half-carry, overflow, parity, carry preservation and the two undocumented copy bits follow the requirements below.

Top module: `alu8_core`

## Requirements
- R1: The flag byte has this layout: bit 0 carry, bit 1 subtract, bit 2 parity/overflow, bit 3 copy of result bit 3, bit 4 half-carry, bit 5 copy of result bit 5, bit 6 zero, bit 7 sign. Operation codes are:
  - ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, NEG=5;
  - AND=6, OR=7, XOR=8, TST=9;
  - INC=10, DEC=11;
  - RLC=12, RRC=13, RL=14, RR=15, SLA=16, SRA=17, SLL=18, SRL=19;
  - RLCA=20, RRCA=21, RLA=22, RRA=23;
  - MUL=24.
- R2: ADD and ADC return `acc_i + opd_i (+ carry-in for ADC)` modulo 256. Carry is the ninth bit of the sum. Half-carry is bit 4 of (A xor operand xor result). Overflow is set when both operands have the same sign and the result's sign differs. The subtract flag is 0.
- R3: SUB and SBC return `acc_i - opd_i (- carry-in for SBC)`. Carry is the borrow. Half-carry uses the same xor rule as R2. Overflow is set when the operands differ in sign and the result's sign differs from A. The subtract flag is 1.
- R4: CMP sets flags exactly as SUB would, taking bits 3 and 5 from the difference. It returns `res_o = acc_i` with `acc_we_o = 0`.
- R5: NEG returns `0 - acc_i` with SUB flag rules, where the minuend is 0 and the subtrahend is `acc_i`.
- R6: AND and TST set half-carry to 1, clear carry and subtract, and put even parity of the value in bit 2. OR and XOR do the same but with half-carry 0. TST leaves `res_o = acc_i` and `acc_we_o = 0`.
- R7: INC and DEC add or subtract 1 from `acc_i`. They pass the incoming carry bit through unchanged and recompute every other flag by the R2/R3 rules.
- R8: RLC, RRC, RL, RR, SLA, SRA, SLL and SRL act on `acc_i`. Carry takes the bit shifted out. RL and RR shift in the incoming carry. SRA keeps bit 7. SLL fills bit 0 with 1. Sign, zero and even parity are taken from the result, and half-carry and subtract are cleared.
- R9: RLCA, RRCA, RLA and RRA rotate `acc_i` in the same way as RLC, RRC, RL and RR. They keep incoming flag bits 7, 6 and 2, clear half-carry and subtract, and set carry from the bit shifted out.
- R10: For every operation except MUL and the unused codes, bits 3 and 5 of the flag byte equal bits 3 and 5 of the computed value. That value is the result byte, or the difference for CMP and the AND value for TST.
- R11: MUL drives `prod_o = acc_i * opd_i` (unsigned, 16 bits) and raises `pair_we_o`. It keeps the flag byte unchanged and holds `acc_we_o` at 0.
- R12: Codes 25 to 31 change nothing: `res_o = acc_i`, `flags_o = flags_i`, and both write strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (see R1) |
| acc_i | input | 8 | Accumulator operand; high byte of the pair for MUL |
| opd_i | input | 8 | Second operand; low byte of the pair for MUL |
| flags_i | input | 8 | Incoming flag byte |
| res_o | output | 8 | Result byte |
| flags_o | output | 8 | New flag byte |
| acc_we_o | output | 1 | Accumulator write strobe |
| prod_o | output | 16 | Unsigned product of acc_i and opd_i |
| pair_we_o | output | 1 | Register-pair write strobe (MUL only) |

## Verification
The block has no internal state, so an error in an internal select or carry path shows at the ports in the same cycle as the stimulus. Most such errors appear only in one flag bit, and only for certain operand patterns. The main cases are:
- A wrong half-carry tap or a swapped overflow formula is visible only for operands that cross a nibble boundary or the signed range.
- A wrong carry-in selection is visible only when the incoming carry is 1.
- A misrouted strobe is visible only for CMP, TST and MUL.
For these reasons the checks pair hand-worked corner vectors with exhaustive operand sweeps and both carry values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
      OP_CMP  = 5'd4,  OP_NEG  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
      OP_XOR  = 5'd8,  OP_TST  = 5'd9,  OP_INC  = 5'd10, OP_DEC  = 5'd11,
      OP_RLC  = 5'd12, OP_RRC  = 5'd13, OP_RL   = 5'd14, OP_RR   = 5'd15,
      OP_SLA  = 5'd16, OP_SRA  = 5'd17, OP_SLL  = 5'd18, OP_SRL  = 5'd19,
      OP_RLCA = 5'd20, OP_RRCA = 5'd21, OP_RLA  = 5'd22, OP_RRA  = 5'd23,
      OP_MUL  = 5'd24
   } alu_op_e;

   localparam int FL_C  = 0;
   localparam int FL_N  = 1;
   localparam int FL_PV = 2;
   localparam int FL_X  = 3;
   localparam int FL_H  = 4;
   localparam int FL_Y  = 5;
   localparam int FL_Z  = 6;
   localparam int FL_S  = 7;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2
   } logic_fn_e;

   function automatic logic [7:0] pack_flags(input logic s, input logic z,
                                             input logic y, input logic h,
                                             input logic x, input logic pv,
                                             input logic n, input logic c);
      logic [7:0] f;
      f        = '0;
      f[FL_S]  = s;
      f[FL_Z]  = z;
      f[FL_Y]  = y;
      f[FL_H]  = h;
      f[FL_X]  = x;
      f[FL_PV] = pv;
      f[FL_N]  = n;
      f[FL_C]  = c;
      return f;
   endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         half_o,
   output logic         ovf_o
);
   localparam int HB = W / 2;

   logic [W:0] ext;
   logic [W:0] xe, ye, ce;

   assign xe = {1'b0, x_i};
   assign ye = {1'b0, y_i};
   assign ce = {{W{1'b0}}, cin_i};

   always_comb begin
      if (sub_i) ext = xe - ye - ce;
      else       ext = xe + ye + ce;
   end

   assign sum_o  = ext[W-1:0];
   assign cout_o = ext[W];

   logic [W-1:0] mix;
   assign mix    = x_i ^ y_i ^ sum_o;
   assign half_o = mix[HB];

   logic [W-1:0] ov_add, ov_sub;
   assign ov_add = ~(x_i ^ y_i) & (y_i ^ sum_o);
   assign ov_sub = (x_i ^ y_i) & (x_i ^ sum_o);
   assign ovf_o  = sub_i ? ov_sub[W-1] : ov_add[W-1];
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
   parameter int W = 8
) (
   input  logic [W-1:0] val_i,
   input  logic         cin_i,
   input  logic [2:0]   kind_i,
   output logic [W-1:0] res_o,
   output logic         cout_o
);
   always_comb begin
      case (kind_i)
         3'd0: begin res_o = {val_i[W-2:0], val_i[W-1]}; cout_o = val_i[W-1]; end
         3'd1: begin res_o = {val_i[0], val_i[W-1:1]};   cout_o = val_i[0];   end
         3'd2: begin res_o = {val_i[W-2:0], cin_i};      cout_o = val_i[W-1]; end
         3'd3: begin res_o = {cin_i, val_i[W-1:1]};      cout_o = val_i[0];   end
         3'd4: begin res_o = {val_i[W-2:0], 1'b0};       cout_o = val_i[W-1]; end
         3'd5: begin res_o = {val_i[W-1], val_i[W-1:1]}; cout_o = val_i[0];   end
         3'd6: begin res_o = {val_i[W-2:0], 1'b1};       cout_o = val_i[W-1]; end
         default: begin res_o = {1'b0, val_i[W-1:1]};    cout_o = val_i[0];   end
      endcase
   end
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
   parameter int W     = 8,
   parameter int STYLE = 1
) (
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   output logic [2*W-1:0] p_o
);
   localparam int PW = 2 * W;

   generate
      if (STYLE == 0) begin : g_op
         assign p_o = PW'(a_i) * PW'(b_i);
      end else begin : g_array
         logic [PW-1:0] part [0:W];
         assign part[0] = '0;
         for (genvar i = 0; i < W; i++) begin : g_row
            logic [PW-1:0] addend;
            assign addend    = b_i[i] ? (PW'(a_i) << i) : '0;
            assign part[i+1] = part[i] + addend;
         end
         assign p_o = part[W];
      end
   endgenerate
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
   parameter int DATA_W    = 8,
   parameter int OP_W      = 5,
   parameter int MUL_STYLE = 1
) (
   input  logic [OP_W-1:0]     op_i,
   input  logic [DATA_W-1:0]   acc_i,
   input  logic [DATA_W-1:0]   opd_i,
   input  logic [7:0]          flags_i,
   output logic [DATA_W-1:0]   res_o,
   output logic [7:0]          flags_o,
   output logic                acc_we_o,
   output logic [2*DATA_W-1:0] prod_o,
   output logic                pair_we_o
);
   import alu8_pkg::*;

   localparam int LAST_OP = 24;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("alu8_core: flag layout requires DATA_W == 8");
      end
      if (OP_W < 5) begin : g_bad_op
         $error("alu8_core: OP_W too small for the operation set");
      end
      if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_mul
         $error("alu8_core: MUL_STYLE must be 0 or 1");
      end
   endgenerate

   logic [4:0] opc;
   assign opc = op_i[4:0];

   logic cin;
   assign cin = flags_i[FL_C];

   // add/subtract operand selection
   logic [DATA_W-1:0] as_x, as_y, as_sum;
   logic as_cin, as_sub, as_cout, as_half, as_ovf;

   always_comb begin
      as_x   = acc_i;
      as_y   = opd_i;
      as_cin = 1'b0;
      as_sub = 1'b0;
      case (opc)
         OP_ADC: as_cin = cin;
         OP_SUB, OP_CMP: as_sub = 1'b1;
         OP_SBC: begin as_sub = 1'b1; as_cin = cin; end
         OP_NEG: begin as_x = '0; as_y = acc_i; as_sub = 1'b1; end
         OP_INC: as_y = DATA_W'(1);
         OP_DEC: begin as_y = DATA_W'(1); as_sub = 1'b1; end
         default: ;
      endcase
   end

   alu8_addsub #(.W(DATA_W)) addsub_i (
      .x_i(as_x), .y_i(as_y), .cin_i(as_cin), .sub_i(as_sub),
      .sum_o(as_sum), .cout_o(as_cout), .half_o(as_half), .ovf_o(as_ovf)
   );

   // bitwise logic
   logic [DATA_W-1:0] lg_res;
   logic_fn_e lg_fn;
   always_comb begin
      case (opc)
         OP_OR:   lg_fn = LG_OR;
         OP_XOR:  lg_fn = LG_XOR;
         default: lg_fn = LG_AND;
      endcase
      case (lg_fn)
         LG_OR:   lg_res = acc_i | opd_i;
         LG_XOR:  lg_res = acc_i ^ opd_i;
         default: lg_res = acc_i & opd_i;
      endcase
   end

   // rotate and shift; accumulator forms reuse kinds 0..3
   logic [4:0] sh_idx;
   logic [DATA_W-1:0] sh_res;
   logic sh_cout;
   assign sh_idx = opc - 5'd12;

   alu8_shift #(.W(DATA_W)) shift_i (
      .val_i(acc_i), .cin_i(cin), .kind_i(sh_idx[2:0]),
      .res_o(sh_res), .cout_o(sh_cout)
   );

   alu8_mul #(.W(DATA_W), .STYLE(MUL_STYLE)) mul_i (
      .a_i(acc_i), .b_i(opd_i), .p_o(prod_o)
   );

   // result and flag assembly
   logic [DATA_W-1:0] val;
   logic val_zero, val_par;
   always_comb begin
      res_o     = acc_i;
      flags_o   = flags_i;
      acc_we_o  = 1'b0;
      pair_we_o = 1'b0;
      val       = acc_i;
      if (opc <= OP_NEG || opc == OP_INC || opc == OP_DEC) begin
         val = as_sum;
      end else if (opc <= OP_TST) begin
         val = lg_res;
      end else if (opc <= OP_RRA) begin
         val = sh_res;
      end
      val_zero = (val == '0);
      val_par  = ~^val;

      case (opc)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
            flags_o = pack_flags(val[7], val_zero, val[5], as_half, val[3],
                                 as_ovf, as_sub, as_cout);
            if (opc != OP_CMP) begin
               res_o    = val;
               acc_we_o = 1'b1;
            end
         end
         OP_INC, OP_DEC: begin
            flags_o  = pack_flags(val[7], val_zero, val[5], as_half, val[3],
                                  as_ovf, as_sub, cin);
            res_o    = val;
            acc_we_o = 1'b1;
         end
         OP_AND, OP_OR, OP_XOR, OP_TST: begin
            flags_o = pack_flags(val[7], val_zero, val[5],
                                 (opc == OP_AND) || (opc == OP_TST),
                                 val[3], val_par, 1'b0, 1'b0);
            if (opc != OP_TST) begin
               res_o    = val;
               acc_we_o = 1'b1;
            end
         end
         OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SLA, OP_SRA, OP_SLL, OP_SRL: begin
            flags_o  = pack_flags(val[7], val_zero, val[5], 1'b0, val[3],
                                  val_par, 1'b0, sh_cout);
            res_o    = val;
            acc_we_o = 1'b1;
         end
         OP_RLCA, OP_RRCA, OP_RLA, OP_RRA: begin
            flags_o  = pack_flags(flags_i[FL_S], flags_i[FL_Z], val[5], 1'b0,
                                  val[3], flags_i[FL_PV], 1'b0, sh_cout);
            res_o    = val;
            acc_we_o = 1'b1;
         end
         OP_MUL: pair_we_o = 1'b1;
         default: ;
      endcase
      if (32'(opc) > LAST_OP) begin
         pair_we_o = 1'b0;
      end
   end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
   input logic [4:0]  op_i,
   input logic [7:0]  acc_i,
   input logic [7:0]  opd_i,
   input logic [7:0]  flags_i,
   input logic [7:0]  res_o,
   input logic [7:0]  flags_o,
   input logic        acc_we_o,
   input logic [15:0] prod_o,
   input logic        pair_we_o
);
   logic is_arith, is_logic, is_shift, is_arot;
   assign is_arith = (op_i <= 5'd5) || (op_i == 5'd10) || (op_i == 5'd11);
   assign is_logic = (op_i >= 5'd6) && (op_i <= 5'd9);
   assign is_shift = (op_i >= 5'd12) && (op_i <= 5'd19);
   assign is_arot  = (op_i >= 5'd20) && (op_i <= 5'd23);

   always_comb begin
      // R7
      if (op_i == 5'd10 || op_i == 5'd11)
         incdec_carry_keep_chk: assert (flags_o[0] == flags_i[0]);
      // R4
      if (op_i == 5'd4)
         cmp_no_write_chk: assert (!acc_we_o && res_o == acc_i);
      // R6
      if (is_logic)
         logic_flag_clear_chk: assert (flags_o[1:0] == 2'b00 &&
                                       flags_o[4] == (op_i == 5'd6 || op_i == 5'd9));
      // R9
      if (is_arot)
         acc_rot_keep_chk: assert (flags_o[7] == flags_i[7] && flags_o[6] == flags_i[6] &&
                                   flags_o[2] == flags_i[2] && flags_o[1] == 1'b0);
      // R8
      if (is_shift)
         shift_zero_flag_chk: assert (flags_o[6] == (res_o == 8'h00) && flags_o[1:0] != 2'b11);
      // R3
      if (is_arith)
         sub_flag_chk: assert (flags_o[1] == (op_i == 5'd2 || op_i == 5'd3 || op_i == 5'd4 ||
                                              op_i == 5'd5 || op_i == 5'd11));
      // R11
      if (op_i == 5'd24)
         mul_product_chk: assert (pair_we_o && !acc_we_o && flags_o == flags_i &&
                                  prod_o == 16'(acc_i) * 16'(opd_i));
      // R12
      if (op_i > 5'd24)
         unused_op_idle_chk: assert (!pair_we_o && !acc_we_o && flags_o == flags_i &&
                                     res_o == acc_i);
   end
endmodule

bind alu8_core alu8_core_chk chk_i (
   .op_i(op_i), .acc_i(acc_i), .opd_i(opd_i), .flags_i(flags_i),
   .res_o(res_o), .flags_o(flags_o), .acc_we_o(acc_we_o),
   .prod_o(prod_o), .pair_we_o(pair_we_o)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
   localparam int CLK_HALF   = 10;
   localparam int WD_CYCLES  = 190000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #CLK_HALF clk = ~clk;

   logic [4:0]  op;
   logic [7:0]  acc, opd, flg;
   logic [7:0]  res, flo;
   logic        we, pwe;
   logic [15:0] prod;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   alu8_core dut_i (
      .op_i(op), .acc_i(acc), .opd_i(opd), .flags_i(flg),
      .res_o(res), .flags_o(flo), .acc_we_o(we),
      .prod_o(prod), .pair_we_o(pwe)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h (op=%0d a=%h b=%h f=%h)",
                  tag, got, exp, op, acc, opd, flg);
      end
   endtask

   function automatic int szf(input int r);
      return (r & 8'h80) | ((r == 0) ? 8'h40 : 0) | (r & 8'h28);
   endfunction

   function automatic int evenp(input int r);
      int n = 0;
      for (int i = 0; i < 8; i++) n += (r >> i) & 1;
      return ((n % 2) == 0) ? 4 : 0;
   endfunction

   // independent behavioural model
   task automatic model(input int o, input int a, input int b, input int f,
                        output int r_res, output int r_fl, output int r_we,
                        output int r_pwe, output int r_prod);
      int c, x, y, ci, full, r, cy, h, v, sb;
      c = f & 1; r_res = a; r_fl = f; r_we = 0; r_pwe = 0; r_prod = a * b;
      if (o <= 5 || o == 10 || o == 11) begin
         x = a; y = b; ci = 0; sb = 0;
         case (o)
            1: ci = c;
            2, 4: sb = 1;
            3: begin sb = 1; ci = c; end
            5: begin x = 0; y = a; sb = 1; end
            10: y = 1;
            11: begin y = 1; sb = 1; end
            default: ;
         endcase
         full = sb ? (x - y - ci) : (x + y + ci);
         r  = full & 255;
         cy = sb ? (full < 0 ? 1 : 0) : (full > 255 ? 1 : 0);
         h  = ((x ^ y ^ r) >> 4) & 1;
         if (sb) v = (((x ^ y) & 8'h80) != 0 && ((x ^ r) & 8'h80) != 0) ? 1 : 0;
         else    v = (((x ^ y) & 8'h80) == 0 && ((x ^ r) & 8'h80) != 0) ? 1 : 0;
         if (o == 10 || o == 11) cy = c;
         r_fl = szf(r) | (h << 4) | (v << 2) | (sb << 1) | cy;
         if (o != 4) begin r_res = r; r_we = 1; end
      end else if (o <= 9) begin
         r = (o == 7) ? (a | b) : (o == 8) ? (a ^ b) : (a & b);
         r_fl = szf(r) | ((o == 6 || o == 9) ? 16 : 0) | evenp(r);
         if (o != 9) begin r_res = r; r_we = 1; end
      end else if (o <= 23) begin
         int k = (o >= 20) ? o - 20 : o - 12;
         case (k)
            0: begin r = ((a << 1) | (a >> 7)) & 255; cy = a >> 7; end
            1: begin r = (a >> 1) | ((a & 1) << 7); cy = a & 1; end
            2: begin r = ((a << 1) | c) & 255; cy = a >> 7; end
            3: begin r = (a >> 1) | (c << 7); cy = a & 1; end
            4: begin r = (a << 1) & 255; cy = a >> 7; end
            5: begin r = (a >> 1) | (a & 8'h80); cy = a & 1; end
            6: begin r = ((a << 1) | 1) & 255; cy = a >> 7; end
            default: begin r = a >> 1; cy = a & 1; end
         endcase
         if (o >= 20) r_fl = (f & 8'hC4) | (r & 8'h28) | cy;
         else         r_fl = szf(r) | evenp(r) | cy;
         r_res = r; r_we = 1;
      end else if (o == 24) begin
         r_pwe = 1;
      end
   endtask

   task automatic apply(input int o, input int a, input int b, input int f);
      op = 5'(o); acc = 8'(a); opd = 8'(b); flg = 8'(f);
      #1;
   endtask

   task automatic cmp_model(input string tag);
      int er, ef, ew, ep, epr;
      model(op, acc, opd, flg, er, ef, ew, ep, epr);
      chk({tag, " res"}, 32'(res), 32'(er));
      chk({tag, " flags"}, 32'(flo), 32'(ef));
      chk({tag, " we"}, {30'd0, pwe, we}, 32'({ep[0], ew[0]}));
      if (o_is_mul(op)) chk({tag, " prod"}, 32'(prod), 32'(epr));
   endtask

   function automatic bit o_is_mul(input logic [4:0] o);
      return o == 5'd24;
   endfunction

   task automatic t_reset;
      // R2 idle vector: ADD 0+0 gives zero flag only
      chk("R2 reset-state res", 32'(res), 32'h00);
      chk("R2 reset-state flags", 32'(flo), 32'h40);
      chk("R2 reset-state we", 32'(we), 32'd1);
   endtask

   task automatic t_arith;
      apply(0, 8'h7F, 8'h01, 0);
      chk("R2 add overflow flags", 32'(flo), 32'h94);
      chk("R2 add res", 32'(res), 32'h80);
      apply(1, 8'hFF, 8'h00, 1);
      chk("R2 adc carry-in wrap flags", 32'(flo), 32'h51);
      apply(2, 8'h80, 8'h01, 0);
      chk("R3 sub overflow flags", 32'(flo), 32'h3E);
      apply(4, 8'h10, 8'h20, 0);
      chk("R4 cmp flags", 32'(flo), 32'hA3);
      chk("R4 cmp keeps acc", {23'd0, we, res}, 32'h010);
      apply(5, 8'h80, 8'h55, 0);
      chk("R5 neg res", 32'(res), 32'h80);
      chk("R5 neg flags", 32'(flo), 32'h87);
   endtask

   task automatic t_logic;
      apply(6, 8'hF0, 8'h3C, 8'hFF);
      chk("R6 and flags", 32'(flo), 32'h34);
      apply(9, 8'hF0, 8'h3C, 8'h00);
      chk("R6 tst no write", {23'd0, we, res}, 32'h0F0);
      apply(7, 8'h01, 8'h02, 8'hFF);
      chk("R6 or flags", 32'(flo), 32'h04);
   endtask

   task automatic t_incdec;
      apply(10, 8'hFF, 0, 1);
      chk("R7 inc keeps carry flags", 32'(flo), 32'h51);
      apply(11, 8'h00, 0, 0);
      chk("R7 dec wrap keeps carry clear", 32'(flo & 8'h01), 32'h0);
      chk("R7 dec res", 32'(res), 32'hFF);
   endtask

   task automatic t_shift;
      apply(18, 8'h80, 0, 0);
      chk("R8 sll fills one", {24'd0, res}, 32'h01);
      chk("R8 sll flags", 32'(flo), 32'h01);
      apply(17, 8'h81, 0, 0);
      chk("R8 sra res", 32'(res), 32'hC0);
      chk("R8 sra flags", 32'(flo), 32'h85);
      apply(20, 8'h80, 0, 8'hC4);
      chk("R9 rlca res", 32'(res), 32'h01);
      chk("R9 rlca keeps S Z P", 32'(flo), 32'hC5);
      apply(23, 8'h28, 0, 8'h01);
      chk("R10 rra copy bits", 32'(flo & 8'h28), 32'(8'h94 & 8'h28));
   endtask

   task automatic t_mul;
      apply(24, 8'h0F, 8'h11, 8'h5A);
      chk("R11 mul prod", 32'(prod), 32'h00FF);
      chk("R11 mul flags kept", 32'(flo), 32'h5A);
      chk("R11 mul strobes", {30'd0, pwe, we}, 32'd2);
      apply(24, 8'hFF, 8'hFF, 0);
      chk("R11 mul max", 32'(prod), 32'hFE01);
   endtask

   task automatic t_unused;
      for (int o = 25; o < 32; o++) begin
         apply(o, 8'h3C, 8'h99, 8'hA5);
         chk("R12 unused res", 32'(res), 32'h3C);
         chk("R12 unused flags", 32'(flo), 32'hA5);
         chk("R12 unused strobes", {30'd0, pwe, we}, 32'd0);
      end
   endtask

   task automatic t_sweep_binary;
      // R1 R2 R3 R10: all operand pairs, both carries, carry-using ops
      for (int o = 1; o <= 3; o += 2)
         for (int c = 0; c < 2; c++)
            for (int a = 0; a < 256; a++)
               for (int b = 0; b < 256; b++) begin
                  apply(o, a, b, c | 8'h28);
                  cmp_model("R1 sweep binary");
               end
   endtask

   task automatic t_sweep_unary;
      // R5 R7 R8 R9 R10 R11: every opcode against the model, both carries
      for (int o = 0; o < 25; o++)
         for (int c = 0; c < 2; c++)
            for (int a = 0; a < 256; a++) begin
               apply(o, a, (a * 37 + 11) & 255, (c == 1) ? 8'hD5 : 8'h44);
               cmp_model("R10 sweep all ops");
            end
   endtask

   initial begin
      apply(0, 0, 0, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_arith();
      t_logic();
      t_incdec();
      t_shift();
      t_mul();
      t_unused();
      t_sweep_binary();
      t_sweep_unary();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(WD_CYCLES * 2 * CLK_HALF);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule